// File: doc/BRIEF.md
# Broad-Pulse Vertical Sync Detector

This block finds the vertical sync interval in a composite sync stream. The stream is digitized and active low, and it is sampled once per clock. A saturating up/down integrator accumulates while sync is low and drains while sync is high. The broad pulses of the vertical interval push the integrator well beyond anything that line sync or equalizing pulses can reach.

The integrator is judged only at sync rising edges, and each judgement updates a qualification flag. The vertical output does not follow the flag directly. It is clocked active on a rising edge that both follows a qualified edge and is itself qualified. It is clocked inactive on the rising edge that completes a set number of unqualified edges. Because the output starts and ends on sync edges, its width is fixed by the field structure, and isolated impulses do not create a vertical pulse.

The sync input is a plain level with no handshake. A new sample is taken on every clock and the block never stalls, so no back-pressure exists. The two outputs are plain status pins. All times are counted in clock cycles: the integrator limit, the threshold, the drain step and the release edge count are parameters.

Top module: `vsync_detector`

## Requirements
- R1: While reset is low, and after its release until the first sync rising edge, `vsync_n` is 1 (inactive) and `vflag` is 0.
- R2: A sync rising edge is a clock where `csync_n` is sampled 1 after being sampled 0. On such an edge, if the integrator holds at least THRESH (default 16), `vflag` becomes 1. From an empty integrator, a low run of exactly 16 clocks sets the flag and a run of 15 clocks does not.
- R3: On a sync rising edge where the integrator holds less than THRESH, `vflag` becomes 0.
- R4: `vflag` changes only in the clock that follows the sample making a rising edge. That is, it is registered one clock after the first high sample and holds its value at all other times.
- R5: `vsync_n` goes to 0 only on a rising edge where `vflag` was already 1 and the integrator is again at or above THRESH. It changes only in the clock after a rising edge.
- R6: A single over-threshold pulse that is followed by a short pulse sets `vflag` but never drives `vsync_n` low.
- R7: While `vsync_n` is 0, it returns to 1 on the END_EDGES-th (default 2) consecutive rising edge that falls below the threshold. The first such edge is the one that clears `vflag`.
- R8: While `vsync_n` is 0, a rising edge at or above the threshold restarts the count of sub-threshold edges from zero.
- R9: With 32-clock half lines, 27-clock broad pulses and 2-clock equalizing pulses, the vertical pulse is 167 clocks wide. An extra pre-equalizing pulse leaves that width unchanged.
- R10: The integrator adds 1 per low sample and removes DN_STEP (default 4) per high sample. It saturates at 0 and CNT_MAX (default 24). Repeated one-clock low glitches with two high clocks between them never set `vflag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Composite sync level, active low, one sample per clock |
| vsync_n | output | 1 | Vertical sync, active low, fixed width |
| vflag | output | 1 | Integrator qualification flag, exposed for debug |

## Verification
The hardest state to reach is a vertical pulse that has already counted one sub-threshold edge and then meets a qualifying edge again. Only an over-threshold pulse placed between post-equalizing pulses produces it. The bench builds that field from one segment task: broad pulses, one equalizing pulse, one inserted broad pulse, then equalizing pulses, one at a time. It checks that the output survives the first short pulse and releases only after the second. The exact-threshold boundary is reached by emptying the integrator with a full line first, then applying low runs of THRESH-1 and THRESH clocks.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [0:0] {
    VS_IDLE   = 1'b0,
    VS_ACTIVE = 1'b1
  } vs_state_e;
endpackage

// File: rtl/vsd_edge.sv
module vsd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic rise
);
  logic prev_q;

  // Idle level is high, so reset to 1 to avoid a spurious edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_n;
  end

  assign rise = sync_n & ~prev_q;
endmodule

// File: rtl/vsd_integrator.sv
module vsd_integrator #(
  parameter int CNT_MAX = 24,
  parameter int DN_STEP = 4,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] STEP  = CNT_W'(DN_STEP);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!sync_n) begin
      cnt_d = (cnt_q >= LIMIT) ? LIMIT : cnt_q + CNT_W'(1);
    end else begin
      cnt_d = (cnt_q <= STEP) ? '0 : cnt_q - STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/vsd_gate.sv
module vsd_gate
  import vsd_pkg::*;
#(
  parameter int THRESH    = 16,
  parameter int END_EDGES = 2,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [CNT_W-1:0] cnt,
  output logic             vflag,
  output logic             vsync_n
);
  localparam int EDGE_W = $clog2(END_EDGES + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(END_EDGES - 1);

  vs_state_e         state_q;
  logic              flag_q;
  logic [EDGE_W-1:0] edges_q;
  logic              above;

  assign above = (cnt >= CNT_W'(THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VS_IDLE;
      flag_q  <= 1'b0;
      edges_q <= '0;
    end else if (rise) begin
      flag_q <= above;
      case (state_q)
        VS_IDLE: begin
          if (flag_q && above) begin
            state_q <= VS_ACTIVE;
            edges_q <= '0;
          end
        end
        VS_ACTIVE: begin
          if (above) begin
            edges_q <= '0;
          end else if (edges_q == LAST_EDGE) begin
            state_q <= VS_IDLE;
            edges_q <= '0;
          end else begin
            edges_q <= edges_q + EDGE_W'(1);
          end
        end
        default: state_q <= VS_IDLE;
      endcase
    end
  end

  assign vflag   = flag_q;
  assign vsync_n = (state_q != VS_ACTIVE);
endmodule

// File: rtl/vsync_detector.sv
module vsync_detector #(
  parameter int THRESH    = 16,
  parameter int CNT_MAX   = 24,
  parameter int DN_STEP   = 4,
  parameter int END_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic vsync_n,
  output logic vflag
);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic             rise_w;
  logic [CNT_W-1:0] cnt_w;

  vsd_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_n (csync_n),
    .rise   (rise_w)
  );

  vsd_integrator #(
    .CNT_MAX (CNT_MAX),
    .DN_STEP (DN_STEP),
    .CNT_W   (CNT_W)
  ) u_integ (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_n (csync_n),
    .cnt    (cnt_w)
  );

  vsd_gate #(
    .THRESH    (THRESH),
    .END_EDGES (END_EDGES),
    .CNT_W     (CNT_W)
  ) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise_w),
    .cnt     (cnt_w),
    .vflag   (vflag),
    .vsync_n (vsync_n)
  );
endmodule

// File: rtl/vsd_chk.sv
module vsd_chk #(
  parameter int CNT_MAX = 24,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic [CNT_W-1:0] cnt,
  input logic             vflag,
  input logic             vsync_n
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (vsync_n && !vflag));

  // R4
  flag_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vflag) |-> $past(rise));

  // R5
  vs_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_n) |-> $past(rise));

  // R6
  vs_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (vflag && $past(vflag)));

  // R7
  vs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> !vflag);

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));
endmodule

bind vsync_detector vsd_chk #(
  .CNT_MAX (CNT_MAX),
  .CNT_W   (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rise    (rise_w),
  .cnt     (cnt_w),
  .vflag   (vflag),
  .vsync_n (vsync_n)
);

// File: tb/tb_vsync_detector.sv
`timescale 1ns/1ps
module tb_vsync_detector;
  localparam int TH  = 16;
  localparam int MX  = 24;
  localparam int DN  = 4;
  localparam int END = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic vsync_n, vflag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vsync_detector #(.THRESH(TH), .CNT_MAX(MX), .DN_STEP(DN), .END_EDGES(END)) dut (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .vsync_n(vsync_n), .vflag(vflag)
  );

  // Behavioural reference model
  int m_cnt = 0, m_edges = 0;
  bit m_prev = 1'b1, m_flag = 1'b0, m_act = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_edges = 0; m_prev = 1'b1; m_flag = 1'b0; m_act = 1'b0;
    end else begin
      bit r, ab;
      r  = csync_n && !m_prev;
      ab = (m_cnt >= TH);
      if (r) begin
        if (!m_act) begin
          if (m_flag && ab) begin m_act = 1'b1; m_edges = 0; end
        end else if (ab) begin
          m_edges = 0;
        end else begin
          m_edges++;
          if (m_edges == END) begin m_act = 1'b0; m_edges = 0; end
        end
        m_flag = ab;
      end
      if (!csync_n) m_cnt = (m_cnt + 1 > MX) ? MX : m_cnt + 1;
      else          m_cnt = (m_cnt - DN < 0) ? 0 : m_cnt - DN;
      m_prev = csync_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison and pulse width tracking
  int falls = 0, run = 0, last_width = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(vflag == m_flag, "R4 vflag vs model", vflag, m_flag);
      check(vsync_n == !m_act, "R5 vsync_n vs model", vsync_n, !m_act);
      if (!vsync_n) begin
        if (run == 0) falls++;
        run++;
      end else if (run != 0) begin
        last_width = run;
        run = 0;
      end
    end
  end

  task automatic seg(input int lo, input int hi);
    csync_n = 1'b0;
    repeat (lo) @(negedge clk);
    csync_n = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) seg(5, 59);
  endtask

  task automatic eqs(input int n);
    for (int i = 0; i < n; i++) seg(2, 30);
  endtask

  task automatic broads(input int n);
    for (int i = 0; i < n; i++) seg(27, 5);
  endtask

  task automatic field(input int npre);
    lines(4); eqs(npre); broads(6); eqs(6); lines(3);
  endtask

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    check(vsync_n == 1'b1, "R1 reset vsync_n", vsync_n, 1);
    check(vflag == 1'b0, "R1 reset vflag", vflag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(vsync_n == 1'b1 && vflag == 1'b0, "R1 after release", {vsync_n, vflag}, 2);

    // R2 threshold boundary
    lines(2);
    seg(TH - 1, 40);
    check(vflag == 1'b0, "R2 run of THRESH-1", vflag, 0);
    lines(1);
    f0 = falls;
    seg(TH, 40);
    check(vflag == 1'b1, "R2 run of THRESH", vflag, 1);
    // R3 / R6: next short pulse clears flag, no vertical pulse
    lines(2);
    check(vflag == 1'b0, "R3 flag cleared", vflag, 0);
    check(falls == f0, "R6 lone long pulse", falls - f0, 0);

    // R10 glitch immunity
    for (int i = 0; i < 20; i++) seg(1, 2);
    lines(1);
    check(vflag == 1'b0 && falls == f0, "R10 glitches", vflag, 0);

    // R5 / R7 / R9 standard field
    field(6);
    check(falls == f0 + 1, "R5 one vertical pulse", falls - f0, 1);
    check(last_width == 167, "R9 width standard field", last_width, 167);
    check(vsync_n == 1'b1, "R7 released", vsync_n, 1);

    // R9 extra pre-equalizing pulse
    field(7);
    check(last_width == 167, "R9 width extra pre-eq", last_width, 167);

    // R8 requalify inside active window
    lines(4); eqs(6); broads(6); eqs(1);
    check(vsync_n == 1'b0, "R8 active after first eq", vsync_n, 0);
    broads(1); eqs(1);
    check(vsync_n == 1'b0, "R8 count restarted", vsync_n, 0);
    eqs(1);
    check(vsync_n == 1'b1, "R7 release after restart", vsync_n, 1);
    lines(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule